// File: doc/BRIEF.md
# Overflow-Paced Two-Wire Bus Clock Generator

This block produces the serial clock for the master side of a two-wire bus. It has no divider of its own: each clock phase is measured in overflow pulses from one of four timer sources that other logic on the chip also uses. A 2-bit select picks the source. The low phase lasts one overflow period and the high phase lasts two, so each bit takes three overflow periods and the bit rate is the overflow rate divided by three.

The generator only ever drives the line low. It reads back the real line level, so a slave, or a competing master, that holds the clock low lengthens the bit rather than shortening a phase. It also gives the data path two strobes. The launch strobe marks when SDA may change after the clock falls. The sample strobe marks when SDA may be read after the clock rises. An extended-hold input lengthens both the hold window and the setup window by parameterised cycle counts. The generator runs bit after bit while a run request is high, and it is cleared at once when master mode is dropped.

Top module: `ovf_scl_gen`

## Requirements
- R1: The select field picks the overflow strobe: 00 picks `ovf_tick[0]`, 01 picks `ovf_tick[1]`, 10 picks `ovf_tick[2]` (third timer, high byte), and 11 picks `ovf_tick[3]` (third timer, low byte). While `master_en` or `free_to_en` is high, `src_tick` follows the selected strobe in the same cycle.
- R2: While both `master_en` and `free_to_en` are low, `src_tick` stays 0. Overflow strobes and run requests then leave `scl_drive_low` at 0.
- R3: The low phase holds `scl_drive_low` high until LOW_TICKS overflow strobes (default 1) have been seen and the setup window has closed. With one strobe every P cycles and P large, the low phase lasts P cycles.
- R4: The high phase counts overflow strobes only in cycles where `scl_in` is high. A strobe in the first cycle the line reads high does count. After HIGH_TICKS strobes (default 2) the line is driven low again. In steady running, one bit lasts 3P cycles and the high phase lasts 2P cycles. Strobes that arrive while another device holds the line low are ignored.
- R5: `bit_done` pulses for one cycle when a high phase completes. If `run_req` is high at that point, `scl_drive_low` rises in the same cycle. If it is low, the block goes idle with the line released.
- R6: `sda_launch` pulses once per low phase. Counting the first cycle of `scl_drive_low` as cycle 0, the pulse comes in cycle 1 with `ext_hold` low and in cycle EXT_HOLD_CYC with `ext_hold` high.
- R7: The line is released no earlier than the end of low-phase cycle 2 with `ext_hold` low, or cycle EXT_HOLD_CYC+EXT_SETUP_CYC with it high. With a strobe in every cycle, the low phase therefore lasts 3 cycles, or EXT_HOLD_CYC+EXT_SETUP_CYC+1 cycles.
- R8: `sda_sample` pulses exactly once per high phase, in the first cycle in which `scl_in` reads high. It is never high while the line is held low.
- R9: When `master_en` is low at a clock edge, the next cycle shows the line released and `bit_done` low, and all phase counters are cleared. A high phase that was cut short needs its full count again.
- R10: After reset the block is idle, with every output low. From idle, `master_en` and `run_req` together drive the line low in the next cycle, and no `bit_done` pulse comes with that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ovf_tick | input | 4 | One-cycle overflow strobes from the four timer sources |
| src_sel | input | 2 | Overflow source select |
| master_en | input | 1 | Master mode active |
| free_to_en | input | 1 | Free-timeout detection active (keeps the source in use) |
| ext_hold | input | 1 | Extended SDA setup and hold windows |
| run_req | input | 1 | Request to keep running bit cycles |
| scl_in | input | 1 | Sensed level of the SCL line |
| src_tick | output | 1 | Gated selected overflow strobe |
| scl_drive_low | output | 1 | Drive SCL low (released when 0) |
| bit_done | output | 1 | One-cycle strobe at the end of each completed high phase |
| sda_launch | output | 1 | SDA may change now (hold window has closed) |
| sda_sample | output | 1 | SDA may be read now (first cycle with SCL high) |

## Verification
Two cases are checked where two events fall in the same clock cycle. In the first, another device lets go of SCL in the very cycle an overflow strobe arrives. That strobe must count towards the high phase, so one more strobe is enough to finish the bit. In the second, master mode drops in the cycle of the strobe that would complete the high phase. Here the disable must win: no `bit_done`, SCL released, and a fresh high phase that again needs two strobes. The bench sets up both cases with one-cycle strobes that it drives by hand. It judges them from the `bit_done` and drive outputs, cycle by cycle.

// File: rtl/ovf_scl_pkg.sv
// Shared types for the overflow-paced bus clock generator.
package ovf_scl_pkg;

    // Phase of the generated clock.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_t;

endpackage

// File: rtl/ovf_src_sel.sv
// Overflow source selector.
// Picks one of N_SRC timer overflow strobes and passes it on only while
// master mode or free-timeout detection needs a time base.
// Assumes each strobe is at most one cycle wide per overflow.
module ovf_src_sel #(
    parameter int N_SRC = 4,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] ovf_tick,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             master_en,
    input  logic             free_to_en,
    output logic             src_tick
);

    // Gate the selected strobe with the "time base in use" condition.
    always_comb begin
        src_tick = (master_en || free_to_en) && ovf_tick[src_sel];
    end

endmodule

// File: rtl/sda_timing.sv
// SDA hold and setup window timer.
// Counts system cycles from the start of a low phase. It flags when SDA
// may be launched (hold window closed) and when the low phase may end
// (setup window closed as well).
// Assumes EXT_HOLD_CYC >= 1 and EXT_SETUP_CYC >= 1.
module sda_timing #(
    parameter int EXT_HOLD_CYC  = 75,
    parameter int EXT_SETUP_CYC = 63,
    localparam int CAP = EXT_HOLD_CYC + EXT_SETUP_CYC,
    localparam int CW  = $clog2(CAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_low,
    input  logic ext_hold,
    output logic sda_launch,
    output logic low_ready
);

    logic [CW-1:0] lcnt;
    logic [CW-1:0] hold_cyc;
    logic [CW-1:0] setup_cyc;

    // Cycles since the low phase began, saturating at CAP.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_low) begin
            lcnt <= '0;
        end else if (lcnt != CW'(CAP)) begin
            lcnt <= lcnt + 1'b1;
        end
    end

    // Pick the window lengths and decode the two strobes.
    always_comb begin
        hold_cyc   = ext_hold ? CW'(EXT_HOLD_CYC)  : CW'(1);
        setup_cyc  = ext_hold ? CW'(EXT_SETUP_CYC) : CW'(1);
        sda_launch = in_low && (lcnt == hold_cyc);
        low_ready  = lcnt >= (hold_cyc + setup_cyc);
    end

endmodule

// File: rtl/scl_phase_seq.sv
// Clock phase sequencer.
// Walks idle -> low -> high -> low ... and counts overflow strobes in each
// phase. The high-phase count only advances while the sensed line is high,
// so a device stretching the clock pauses it.
// Assumes LOW_TICKS >= 1 and HIGH_TICKS >= 1.
module scl_phase_seq
    import ovf_scl_pkg::*;
#(
    parameter int LOW_TICKS  = 1,
    parameter int HIGH_TICKS = 2,
    localparam int LW = $clog2(LOW_TICKS + 1),
    localparam int HW = $clog2(HIGH_TICKS + 1)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   master_en,
    input  logic   run_req,
    input  logic   tick,
    input  logic   scl_in,
    input  logic   low_ready,
    output phase_t phase,
    output logic   bit_done,
    output logic   sda_sample
);

    logic [LW-1:0] low_cnt;
    logic [HW-1:0] hi_cnt;
    logic          hi_seen;
    logic          low_met;
    logic          hi_last;

    // Decode the end-of-phase conditions, counting this cycle's strobe.
    always_comb begin
        low_met = (low_cnt == LW'(LOW_TICKS)) ||
                  (tick && (low_cnt == LW'(LOW_TICKS - 1)));
        hi_last = tick && scl_in && (hi_cnt == HW'(HIGH_TICKS - 1));
        sda_sample = (phase == PH_HIGH) && scl_in && !hi_seen;
    end

    // Phase state and counters; a master disable clears everything.
    always_ff @(posedge clk) begin
        if (!rst_n || !master_en) begin
            phase    <= PH_IDLE;
            low_cnt  <= '0;
            hi_cnt   <= '0;
            hi_seen  <= 1'b0;
            bit_done <= 1'b0;
        end else begin
            bit_done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    low_cnt <= '0;
                    if (run_req) begin
                        phase <= PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (low_met && low_ready) begin
                        phase   <= PH_HIGH;
                        hi_cnt  <= '0;
                        hi_seen <= 1'b0;
                    end else if (tick && (low_cnt != LW'(LOW_TICKS))) begin
                        low_cnt <= low_cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (scl_in) begin
                        hi_seen <= 1'b1;
                    end
                    if (hi_last) begin
                        bit_done <= 1'b1;
                        low_cnt  <= '0;
                        phase    <= run_req ? PH_LOW : PH_IDLE;
                    end else if (tick && scl_in) begin
                        hi_cnt <= hi_cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ovf_scl_gen.sv
// Overflow-paced bus clock generator, top level.
// Ties the source selector, the phase sequencer and the SDA window timer
// together. SCL is only ever pulled low; the line level comes back on scl_in.
// Assumes the overflow strobes are synchronous to clk.
module ovf_scl_gen
    import ovf_scl_pkg::*;
#(
    parameter int N_SRC         = 4,
    parameter int LOW_TICKS     = 1,
    parameter int HIGH_TICKS    = 2,
    parameter int EXT_HOLD_CYC  = 75,
    parameter int EXT_SETUP_CYC = 63,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] ovf_tick,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             master_en,
    input  logic             free_to_en,
    input  logic             ext_hold,
    input  logic             run_req,
    input  logic             scl_in,
    output logic             src_tick,
    output logic             scl_drive_low,
    output logic             bit_done,
    output logic             sda_launch,
    output logic             sda_sample
);

    phase_t phase;
    logic   low_ready;

    ovf_src_sel #(.N_SRC(N_SRC)) u_sel (
        .ovf_tick   (ovf_tick),
        .src_sel    (src_sel),
        .master_en  (master_en),
        .free_to_en (free_to_en),
        .src_tick   (src_tick)
    );

    scl_phase_seq #(.LOW_TICKS(LOW_TICKS), .HIGH_TICKS(HIGH_TICKS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_en  (master_en),
        .run_req    (run_req),
        .tick       (src_tick),
        .scl_in     (scl_in),
        .low_ready  (low_ready),
        .phase      (phase),
        .bit_done   (bit_done),
        .sda_sample (sda_sample)
    );

    // The line is driven low for exactly the low phase.
    always_comb begin
        scl_drive_low = (phase == PH_LOW);
    end

    sda_timing #(.EXT_HOLD_CYC(EXT_HOLD_CYC), .EXT_SETUP_CYC(EXT_SETUP_CYC)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_low     (scl_drive_low),
        .ext_hold   (ext_hold),
        .sda_launch (sda_launch),
        .low_ready  (low_ready)
    );

endmodule

// File: rtl/ovf_scl_gen_chk.sv
// Property checker for ovf_scl_gen, attached through bind.
// Only watches ports; keeps one flag of its own for strobes seen in a low phase.
module ovf_scl_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic master_en,
    input logic free_to_en,
    input logic scl_in,
    input logic src_tick,
    input logic scl_drive_low,
    input logic bit_done,
    input logic sda_launch,
    input logic sda_sample
);

    logic seen_tick;

    // Remember whether a strobe arrived during the current low phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !scl_drive_low) begin
            seen_tick <= 1'b0;
        end else if (src_tick) begin
            seen_tick <= 1'b1;
        end
    end

    // R2: no time base leaves the block when neither user needs it.
    a_r2_gated_source: assert property (@(posedge clk) disable iff (!rst_n)
        !(master_en || free_to_en) |-> !src_tick);

    // R3: a release by the sequencer must follow an overflow strobe in that low phase.
    a_r3_release_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_drive_low) && $past(master_en)) |-> $past(seen_tick || src_tick));

    // R4: a high phase only completes on a strobe seen with the line high.
    a_r4_done_on_high_tick: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |-> $past(src_tick && scl_in && master_en));

    // R5: the done strobe lasts a single cycle.
    a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |=> !bit_done);

    // R6: SDA is only launched while the clock is held low.
    a_r6_launch_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        sda_launch |-> scl_drive_low);

    // R8: SDA is only sampled with the line sensed high and not driven.
    a_r8_sample_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        sda_sample |-> (scl_in && !scl_drive_low));

    // R9: dropping master mode releases the line and suppresses done.
    a_r9_master_off: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (!scl_drive_low && !bit_done));

endmodule

bind ovf_scl_gen ovf_scl_gen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .master_en     (master_en),
    .free_to_en    (free_to_en),
    .scl_in        (scl_in),
    .src_tick      (src_tick),
    .scl_drive_low (scl_drive_low),
    .bit_done      (bit_done),
    .sda_launch    (sda_launch),
    .sda_sample    (sda_sample)
);

// File: tb/ovf_scl_gen_tb.sv
`timescale 1ns/1ps
// Directed bench for ovf_scl_gen: one task per scenario, each checking itself.
module ovf_scl_gen_tb;

    localparam int HOLD_X  = 6;
    localparam int SETUP_X = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ovf_tick = '0;
    logic [1:0] src_sel = '0;
    logic       master_en = 1'b0;
    logic       free_to_en = 1'b0;
    logic       ext_hold = 1'b0;
    logic       run_req = 1'b0;
    logic       stretch = 1'b0;
    logic       scl_in;
    logic       src_tick;
    logic       scl_drive_low;
    logic       bit_done;
    logic       sda_launch;
    logic       sda_sample;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    // Wired-AND line: released only when neither we nor the far device pull low.
    assign scl_in = !scl_drive_low && !stretch;

    always #2 clk = ~clk;

    ovf_scl_gen #(.EXT_HOLD_CYC(HOLD_X), .EXT_SETUP_CYC(SETUP_X)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ovf_tick      (ovf_tick),
        .src_sel       (src_sel),
        .master_en     (master_en),
        .free_to_en    (free_to_en),
        .ext_hold      (ext_hold),
        .run_req       (run_req),
        .scl_in        (scl_in),
        .src_tick      (src_tick),
        .scl_drive_low (scl_drive_low),
        .bit_done      (bit_done),
        .sda_launch    (sda_launch),
        .sda_sample    (sda_sample)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply a strobe on the selected source for one clock, then observe.
    task automatic step(input bit tick);
        ovf_tick = tick ? (4'b0001 << src_sel) : 4'b0000;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; master_en = 0; free_to_en = 0; run_req = 0;
        ext_hold = 0; stretch = 0; ovf_tick = '0; src_sel = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(scl_drive_low == 0, "R10 reset drive", scl_drive_low, 0);
        check(bit_done == 0 && sda_launch == 0 && sda_sample == 0,
              "R10 reset strobes", bit_done + sda_launch + sda_sample, 0);
    endtask

    task automatic t_select();
        int bad = 0;
        do_reset();
        master_en = 1;
        for (int s = 0; s < 4; s++) begin
            for (int j = 0; j < 4; j++) begin
                src_sel = 2'(s);
                ovf_tick = 4'b0001 << j;
                #1;
                if (src_tick != (s == j)) bad++;
            end
        end
        check(bad == 0, "R1 select under master", bad, 0);
        master_en = 0; free_to_en = 1; src_sel = 2'd2; ovf_tick = 4'b0100; #1;
        check(src_tick == 1, "R1 free-timeout keeps source", src_tick, 1);
        free_to_en = 0; #1;
        check(src_tick == 0, "R2 gated when unused", src_tick, 0);
        run_req = 1; bad = 0;
        for (int k = 0; k < 8; k++) begin
            step(1);
            if (scl_drive_low || src_tick) bad++;
        end
        check(bad == 0, "R2 ticks and run ignored", bad, 0);
        free_to_en = 1; bad = 0;
        for (int k = 0; k < 8; k++) begin
            step(1);
            if (scl_drive_low) bad++;
        end
        check(bad == 0, "R2 free-timeout alone does not clock", bad, 0);
        ovf_tick = '0;
    endtask

    // Run with a strobe every p cycles and measure steady-state phases.
    task automatic t_measure(input int p, input bit ext, input int n,
                             input int e_low, input int e_high,
                             input int e_launch, input string tag);
        int low_start = -1, fall_c = -1, last_done = -1;
        int low_len = -1, high_len = -1, period = -1, launch_off = -1;
        int dones = 0, samples = 0;
        bit prev = 0;
        do_reset();
        ext_hold = ext; master_en = 1; run_req = 1;
        for (int c = 0; c < n; c++) begin
            step((c % p) == p - 1);
            if (scl_drive_low && !prev) begin
                if (fall_c >= 0) high_len = c - fall_c;
                low_start = c;
            end
            if (!scl_drive_low && prev) begin
                low_len = c - low_start;
                fall_c = c;
            end
            if (sda_launch) launch_off = c - low_start;
            if (sda_sample) samples++;
            if (bit_done) begin
                dones++;
                if (last_done >= 0) period = c - last_done;
                last_done = c;
            end
            prev = scl_drive_low;
        end
        ovf_tick = '0;
        check(low_len == e_low, {tag, " low length"}, low_len, e_low);
        check(high_len == e_high, {tag, " high length"}, high_len, e_high);
        check(period == e_low + e_high, {tag, " bit period"}, period, e_low + e_high);
        check(launch_off == e_launch, {tag, " launch offset"}, launch_off, e_launch);
        check(samples == dones || samples == dones + 1, "R8 one sample per bit",
              samples, dones);
    endtask

    // Stretch: strobes during a held-low line are ignored; release plus strobe counts.
    task automatic t_stretch();
        int bad = 0;
        do_reset();
        master_en = 1; run_req = 1; stretch = 1;
        step(0);
        check(scl_drive_low == 1, "R10 start drives low", scl_drive_low, 1);
        check(bit_done == 0, "R10 no done on start", bit_done, 0);
        step(1);
        for (int k = 0; k < 6 && scl_drive_low; k++) step(0);
        check(scl_drive_low == 0 && scl_in == 0, "R4 released but held by other",
              scl_drive_low, 0);
        for (int k = 0; k < 3; k++) begin
            step(1);
            if (bit_done || scl_drive_low || sda_sample) bad++;
        end
        check(bad == 0, "R4 ticks ignored while stretched", bad, 0);
        stretch = 0; ovf_tick = 4'b0001; #1;
        check(sda_sample == 1, "R8 sample on first high cycle", sda_sample, 1);
        @(negedge clk);
        check(bit_done == 0 && sda_sample == 0, "R4 one tick not enough",
              bit_done + sda_sample, 0);
        step(1);
        check(bit_done == 1, "R4 coincident tick counted", bit_done, 1);
        check(scl_drive_low == 1, "R5 drive with done", scl_drive_low, 1);
        step(0);
        check(bit_done == 0, "R5 done single cycle", bit_done, 1'b0);
    endtask

    // Master disable cuts a phase short and clears the counters.
    task automatic t_master_drop();
        do_reset();
        master_en = 1; run_req = 1;
        step(0);
        master_en = 0; step(0);
        check(scl_drive_low == 0, "R9 release in low phase", scl_drive_low, 0);
        master_en = 1; step(0);
        step(1);
        for (int k = 0; k < 6 && scl_drive_low; k++) step(0);
        step(1);
        check(bit_done == 0, "R4 first high tick", bit_done, 0);
        master_en = 0; step(1);
        check(bit_done == 0 && scl_drive_low == 0, "R9 disable beats completing tick",
              bit_done + scl_drive_low, 0);
        master_en = 1; step(0);
        check(scl_drive_low == 1, "R10 restart drives low", scl_drive_low, 1);
        step(1);
        for (int k = 0; k < 6 && scl_drive_low; k++) step(0);
        step(1);
        check(bit_done == 0, "R9 high count cleared", bit_done, 0);
        step(1);
        check(bit_done == 1, "R9 full count after restart", bit_done, 1);
    endtask

    // Stop: run request low at completion returns to idle, released.
    task automatic t_stop();
        int bad = 0;
        do_reset();
        master_en = 1; run_req = 1;
        step(0); step(1);
        for (int k = 0; k < 6 && scl_drive_low; k++) step(0);
        run_req = 0;
        step(1); step(1);
        check(bit_done == 1 && scl_drive_low == 0, "R5 done then idle",
              bit_done, 1);
        for (int k = 0; k < 5; k++) begin
            step(1);
            if (scl_drive_low || bit_done) bad++;
        end
        check(bad == 0, "R5 stays idle", bad, 0);
    endtask

    initial begin
        t_reset();
        t_select();
        t_measure(20, 0, 400, 20, 40, 1, "R3 R4 R6 paced");
        t_measure(1, 0, 60, 3, 2, 1, "R7 R6 fast");
        t_measure(1, 1, 80, HOLD_X + SETUP_X + 1, 2, HOLD_X, "R7 R6 extended");
        t_stretch();
        t_master_drop();
        t_stop();
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(100000 * 4);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule